// File: doc/BRIEF.md
# Cartridge Real-Time Clock Register Block

This block is a time-of-day counter that sits on the cartridge side of the CPU bus and shares the external RAM window with the RAM banks. One select value, written to the bank-select range, decides whether the window holds a RAM bank or one of five clock registers. The clock keeps seconds, minutes, hours and a 9-bit day number. A single-cycle enable input marks each elapsed second.

Software does not read the running counters directly. A write anywhere in the capture range copies all live counters into a snapshot. Reads in clock mode return fields of that snapshot, so a multi-byte time value stays consistent while the clock keeps running. Writes in clock mode load the selected live field. When a RAM bank is selected, the block flags the access as a RAM access and gives the bank number.

Top module: `cart_rtc`

## Requirements
- R1: After a synchronous reset, all counters and the snapshot are zero, RAM mode is active and the RAM bank output is 0.
- R2: A write in 0x4000..0x5FFF with data 0x00..0x07 sets the RAM bank output to data[2:0] and leaves clock mode.
- R3: A write in 0x4000..0x5FFF with data 0x08..0x0C enters clock mode with that register selected (0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day bits 7:0, 0x0C day bit 8). Data 0x0D..0xFF changes neither the mode, the selected register nor the bank.
- R4: Each tick pulse adds one second. Seconds carry into minutes past 59, minutes into hours past 59, hours into days past 23, and the day count wraps from 511 to 0.
- R5: A write in 0x6000..0x7FFF copies the live counters, as they were before that clock edge, into the snapshot. Ticks after the copy do not change what is read.
- R6: In clock mode, rdata gives the snapshot field of the selected register: seconds, minutes and hours zero-extended; 0x0B gives day bits 7:0; 0x0C gives day bit 8 in data bit 0 and zeros in bits 7:1.
- R7: In clock mode, a write in 0xA000..0xBFFF loads the selected live field with the data truncated to the field width (6 bits for seconds and minutes, 5 bits for hours). Register 0x0B replaces only day bits 7:0. Register 0x0C replaces only day bit 8, taken from data bit 0.
- R8: For a read or write in 0xA000..0xBFFF, clock_hit is 1 in clock mode and ram_access is 1 in RAM mode, never both. rdata is 0xFF in RAM mode.
- R9: A tick in the same cycle as a clock-register write is discarded.
- R10: A field holding a value at or above its rollover limit, through a direct load, goes to 0 on the next increment and carries into the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second enable pulse, one cycle wide |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Snapshot field of the selected clock register, 0xFF in RAM mode |
| clock_hit | output | 1 | Window access is served by the clock |
| ram_access | output | 1 | Window access goes to RAM |
| ram_bank | output | 3 | Selected RAM bank |

## Verification
Directed sequences load each field to its last value and fire one tick, which separates a correct ripple of carries through all four fields from a chain that stops early or wraps at the wrong count. A capture followed by ticks tells a snapshot read apart from a live read, and a tick coinciding with a field write shows which one wins. Select values above 0x0C, oversized write data and fields loaded past their limit probe the ignore, truncation and out-of-range rollover rules. A long seeded random mix of ticks, selects, captures and field writes is then compared against a bench model after every read.

// File: rtl/cart_rtc_pkg.sv
`timescale 1ns/1ps
package cart_rtc_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 9;
    localparam int BANK_W = 3;

    typedef enum logic [7:0] {
        SEL_SEC = 8'h08,
        SEL_MIN = 8'h09,
        SEL_HR  = 8'h0A,
        SEL_DLO = 8'h0B,
        SEL_DHI = 8'h0C
    } rtc_reg_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_SELECT,
        RG_CAPTURE,
        RG_WINDOW
    } region_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } rtc_time_t;

    function automatic region_e region_of(input logic [15:0] a);
        case (a[15:13])
            3'b010:  return RG_SELECT;
            3'b011:  return RG_CAPTURE;
            3'b101:  return RG_WINDOW;
            default: return RG_NONE;
        endcase
    endfunction

    function automatic logic [7:0] field_byte(input rtc_time_t t, input rtc_reg_e s);
        case (s)
            SEL_SEC: return 8'(t.sec);
            SEL_MIN: return 8'(t.min);
            SEL_HR:  return 8'(t.hr);
            SEL_DLO: return t.day[7:0];
            SEL_DHI: return {7'd0, t.day[DAY_W-1]};
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_wrap_cnt.sv
`timescale 1ns/1ps
module rtc_wrap_cnt #(
    parameter int W     = 6,
    parameter int LIMIT = 60
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         carry
);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic at_top;
    assign at_top = (val >= TOP);
    assign carry  = inc & ~ld & at_top;

    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (ld)
            val <= ld_val;
        else if (inc)
            val <= at_top ? '0 : val + 1'b1;
    end

    // R4 / R10: a step from the top value or beyond lands on zero
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && at_top) |=> (val == '0));

    // R4: no step without an increment or a load
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !ld) |=> $stable(val));

    // R7: a load takes the presented value
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> (val == $past(ld_val)));

    // R4: a step below the top adds one
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && !at_top) |=> (val == $past(val) + 1'b1));
endmodule

// File: rtl/rtc_select.sv
`timescale 1ns/1ps
module rtc_select
    import cart_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [7:0]        wdata,
    output logic              clock_mode,
    output rtc_reg_e          reg_sel,
    output logic [BANK_W-1:0] bank
);
    logic pick_bank, pick_clock;
    assign pick_bank  = wr_sel && (wdata < 8'h08);
    assign pick_clock = wr_sel && (wdata >= 8'h08) && (wdata <= 8'h0C);

    always_ff @(posedge clk) begin
        if (rst) begin
            clock_mode <= 1'b0;
            reg_sel    <= SEL_SEC;
            bank       <= '0;
        end else if (pick_bank) begin
            clock_mode <= 1'b0;
            bank       <= wdata[BANK_W-1:0];
        end else if (pick_clock) begin
            clock_mode <= 1'b1;
            reg_sel    <= rtc_reg_e'(wdata);
        end
    end

    a_r2_bank_pick: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata < 8'h08) |=> (!clock_mode && bank == $past(wdata[BANK_W-1:0])));

    a_r3_clock_pick: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata >= 8'h08 && wdata <= 8'h0C) |=> (clock_mode && 8'(reg_sel) == $past(wdata)));

    a_r3_ignore_high: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wdata > 8'h0C) |=> ($stable(clock_mode) && $stable(reg_sel) && $stable(bank)));
endmodule

// File: rtl/rtc_snap.sv
`timescale 1ns/1ps
module rtc_snap
    import cart_rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap,
    input  rtc_time_t live,
    input  logic      clock_mode,
    input  rtc_reg_e  reg_sel,
    output logic [7:0] rdata
);
    rtc_time_t snap;

    always_ff @(posedge clk) begin
        if (rst)
            snap <= '0;
        else if (cap)
            snap <= live;
    end

    assign rdata = clock_mode ? field_byte(snap, reg_sel) : 8'hFF;

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        cap |=> (snap == $past(live)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(snap));
endmodule

// File: rtl/cart_rtc.sv
`timescale 1ns/1ps
module cart_rtc
    import cart_rtc_pkg::*;
#(
    parameter int SEC_LIMIT  = 60,
    parameter int MIN_LIMIT  = 60,
    parameter int HOUR_LIMIT = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              clock_hit,
    output logic              ram_access,
    output logic [BANK_W-1:0] ram_bank
);
    localparam int DAY_LIMIT = 1 << DAY_W;

    region_e   region;
    logic      clock_mode;
    rtc_reg_e  reg_sel;
    rtc_time_t live;
    logic      in_window, field_wr, tick_eff;
    logic      sec_carry, min_carry, hr_carry, day_carry;
    logic      ld_sec, ld_min, ld_hr, ld_day;
    logic [DAY_W-1:0] day_ld_val;

    assign region     = region_of(addr);
    assign in_window  = (region == RG_WINDOW) && (wr_en || rd_en);
    assign clock_hit  = in_window && clock_mode;
    assign ram_access = in_window && !clock_mode;
    assign field_wr   = clock_hit && wr_en;
    assign tick_eff   = tick && !field_wr;

    assign ld_sec = field_wr && (reg_sel == SEL_SEC);
    assign ld_min = field_wr && (reg_sel == SEL_MIN);
    assign ld_hr  = field_wr && (reg_sel == SEL_HR);
    assign ld_day = field_wr && ((reg_sel == SEL_DLO) || (reg_sel == SEL_DHI));
    assign day_ld_val = (reg_sel == SEL_DLO) ? {live.day[DAY_W-1], wdata}
                                             : {wdata[0], live.day[7:0]};

    rtc_select u_select (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (wr_en && region == RG_SELECT),
        .wdata      (wdata),
        .clock_mode (clock_mode),
        .reg_sel    (reg_sel),
        .bank       (ram_bank)
    );

    rtc_wrap_cnt #(.W(SEC_W), .LIMIT(SEC_LIMIT)) u_sec (
        .clk(clk), .rst(rst), .inc(tick_eff), .ld(ld_sec),
        .ld_val(wdata[SEC_W-1:0]), .val(live.sec), .carry(sec_carry));

    rtc_wrap_cnt #(.W(MIN_W), .LIMIT(MIN_LIMIT)) u_min (
        .clk(clk), .rst(rst), .inc(sec_carry), .ld(ld_min),
        .ld_val(wdata[MIN_W-1:0]), .val(live.min), .carry(min_carry));

    rtc_wrap_cnt #(.W(HR_W), .LIMIT(HOUR_LIMIT)) u_hr (
        .clk(clk), .rst(rst), .inc(min_carry), .ld(ld_hr),
        .ld_val(wdata[HR_W-1:0]), .val(live.hr), .carry(hr_carry));

    rtc_wrap_cnt #(.W(DAY_W), .LIMIT(DAY_LIMIT)) u_day (
        .clk(clk), .rst(rst), .inc(hr_carry), .ld(ld_day),
        .ld_val(day_ld_val), .val(live.day), .carry(day_carry));

    rtc_snap u_snap (
        .clk        (clk),
        .rst        (rst),
        .cap        (wr_en && region == RG_CAPTURE),
        .live       (live),
        .clock_mode (clock_mode),
        .reg_sel    (reg_sel),
        .rdata      (rdata)
    );

    a_r4_day_wrap: assert property (@(posedge clk) disable iff (rst)
        day_carry |=> (live.day == '0));

    a_r9_tick_drop: assert property (@(posedge clk) disable iff (rst)
        (tick && field_wr && reg_sel != SEL_SEC) |=> $stable(live.sec));

    a_r8_route: assert property (@(posedge clk) disable iff (rst)
        $onehot0({clock_hit, ram_access}));

    a_r1_reset: assert property (@(posedge clk)
        rst |=> (live == '0 && ram_bank == '0 && !clock_mode));
endmodule

// File: tb/test_cart_rtc.sv
`timescale 1ns/1ps
module test_cart_rtc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        clock_hit, ram_access;
    logic [2:0]  ram_bank;

    int checks = 0;
    int errors = 0;

    // model state
    int m_sec, m_min, m_hr, m_day;
    int s_sec, s_min, s_hr, s_day;
    bit m_clk_mode;
    int m_sel;
    int m_bank;

    cart_rtc i_cart_rtc (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .clock_hit(clock_hit),
        .ram_access(ram_access), .ram_bank(ram_bank));

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_byte();
        if (!m_clk_mode) return 8'hFF;
        case (m_sel)
            8'h08: return s_sec;
            8'h09: return s_min;
            8'h0A: return s_hr;
            8'h0B: return s_day & 8'hFF;
            default: return (s_day >> 8) & 1;
        endcase
    endfunction

    function automatic void bump(inout int v, input int lim, output bit c);
        if (v >= lim - 1) begin v = 0; c = 1; end
        else begin v = v + 1; c = 0; end
    endfunction

    function automatic void model_step(bit t, bit w, logic [15:0] a, logic [7:0] d);
        bit fw = 0;
        bit c;
        if (w) begin
            case (a[15:13])
                3'b010: begin
                    if (d < 8'h08) begin m_clk_mode = 0; m_bank = int'(d[2:0]); end
                    else if (d <= 8'h0C) begin m_clk_mode = 1; m_sel = int'(d); end
                end
                3'b011: begin s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day; end
                3'b101: if (m_clk_mode) begin
                    fw = 1;
                    case (m_sel)
                        8'h08: m_sec = int'(d[5:0]);
                        8'h09: m_min = int'(d[5:0]);
                        8'h0A: m_hr  = int'(d[4:0]);
                        8'h0B: m_day = (m_day & 32'h100) | int'(d);
                        default: m_day = (m_day & 32'hFF) | (int'(d[0]) << 8);
                    endcase
                end
                default: ;
            endcase
        end
        if (t && !fw) begin
            bump(m_sec, 60, c);
            if (c) begin
                bump(m_min, 60, c);
                if (c) begin
                    bump(m_hr, 24, c);
                    if (c) bump(m_day, 512, c);
                end
            end
        end
    endfunction

    task automatic cycle(input bit t, input bit w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = t; wr_en = w; rd_en = 1'b0; addr = a; wdata = d;
        @(posedge clk);
        model_step(t, w, a, d);
        #1;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read_check(input string tag);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; rd_en = 1'b1;
        addr = 16'hA000 | 16'($urandom_range(0, 16'h1FFF));
        #1;
        check(tag, int'(rdata), exp_byte());
        check("R8 clock_hit", int'(clock_hit), int'(m_clk_mode));
        check("R8 ram_access", int'(ram_access), int'(!m_clk_mode));
        check("R2 bank", int'(ram_bank), m_bank);
        rd_en = 1'b0;
    endtask

    task automatic sel(input logic [7:0] v);
        cycle(1'b0, 1'b1, 16'h4000 | 16'($urandom_range(0, 16'h1FFF)), v);
    endtask

    task automatic field_wr(input logic [7:0] r, input logic [7:0] v);
        sel(r);
        cycle(1'b0, 1'b1, 16'hA000 | 16'($urandom_range(0, 16'h1FFF)), v);
    endtask

    task automatic capture();
        cycle(1'b0, 1'b1, 16'h6000 | 16'($urandom_range(0, 16'h1FFF)), 8'($urandom));
    endtask

    task automatic read_all(input string tag);
        for (int r = 8; r <= 12; r++) begin
            sel(8'(r));
            read_check(tag);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd24681));
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
        s_sec = 0; s_min = 0; s_hr = 0; s_day = 0;
        m_clk_mode = 0; m_sel = 8'h08; m_bank = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state through the ports
        read_check("R1 reset rdata");
        read_all("R1 reset fields");

        // R7 / R6: load last values, capture, read back
        field_wr(8'h08, 8'd59);
        field_wr(8'h09, 8'd59);
        field_wr(8'h0A, 8'd23);
        field_wr(8'h0B, 8'hFF);
        field_wr(8'h0C, 8'h01);
        capture();
        read_all("R6 R7 loaded fields");

        // R4: full ripple into day wrap
        cycle(1'b1, 1'b0, 16'h0000, 8'h00);
        capture();
        read_all("R4 ripple wrap");

        // R7: day low write keeps bit 8, high write keeps low byte
        field_wr(8'h0C, 8'hFF);
        field_wr(8'h0B, 8'h34);
        capture();
        read_all("R7 day halves");

        // R5: snapshot isolation
        sel(8'h08);
        capture();
        repeat (5) cycle(1'b1, 1'b0, 16'h0000, 8'h00);
        read_check("R5 frozen snapshot");
        capture();
        read_check("R5 recapture");

        // R3: ignored select values in clock mode
        sel(8'h0D);
        read_check("R3 ignore 0x0D");
        sel(8'hFF);
        read_check("R3 ignore 0xFF");

        // R2: bank select and leaving clock mode, R8 rdata 0xFF
        sel(8'h05);
        read_check("R2 bank 5");
        sel(8'h20);
        read_check("R3 ignore in RAM mode");
        cycle(1'b0, 1'b1, 16'hA123, 8'h77);
        sel(8'h08);
        capture();
        read_check("R8 RAM write leaves clock");

        // R9: tick with a field write is discarded
        sel(8'h09);
        cycle(1'b1, 1'b1, 16'hB000, 8'd10);
        capture();
        read_all("R9 tick dropped");

        // R10 and R7 truncation: out-of-range fields roll on next tick
        field_wr(8'h08, 8'hFF);
        field_wr(8'h0A, 8'hFE);
        capture();
        read_all("R7 truncation");
        field_wr(8'h09, 8'd63);
        cycle(1'b1, 1'b0, 16'h0000, 8'h00);
        capture();
        read_all("R10 out of range roll");

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: cycle(1'b1, 1'b0, 16'($urandom), 8'($urandom));
                3:       sel(8'($urandom_range(0, 16)));
                4:       capture();
                5:       cycle(1'($urandom), 1'b1, 16'hA000 | 16'($urandom_range(0, 16'h1FFF)),
                               (($urandom & 3) == 0) ? 8'($urandom_range(56, 63)) : 8'($urandom));
                6:       cycle(1'($urandom), 1'b1, 16'($urandom), 8'($urandom));
                default: read_check("R4 R5 R6 random");
            endcase
        end
        read_all("R4 R6 final");
        summary();
    end
endmodule